// File: doc/BRIEF.md
# I/O window address translator

This bridge sits between a processor bus and an I/O-space bus. The processor reaches I/O ports by loading and storing inside an 8 MB address window. The bridge turns each such access into one I/O-side request that carries a 16-bit port number, the access size and the data. Accesses can be bytes, halfwords or words.

Two port mappings are available, and an input chooses between them. In the contiguous mapping the port number is simply the low 16 bits of the offset into the window. In the sparse mapping every 4 KB page of processor space covers a group of 32 ports, so each group of device registers can sit on a page of its own. When the processor runs big-endian, halfword and word data is byte-swapped on the way out and on the way back.

A second, 4-byte window returns an interrupt acknowledge vector taken from an input port, and never reaches the I/O side. Accesses that fall in neither window are completed locally with zero read data. Only one transaction is in flight at a time.

Top module: `io_window_bridge`

## Requirements
- R1: While reset is held and on the first cycle after it, cpu_ready is 1, and io_valid and cpu_done are 0.
- R2: An access whose address lies in [0x80000000, 0x80800000) produces exactly one I/O request. An access outside that window and outside the acknowledge window produces no I/O request. It completes with cpu_done in the cycle after acceptance, and a read returns 0.
- R3: When map_sparse is 0 at acceptance, io_port equals bits 15:0 of the offset into the window.
- R4: When map_sparse is 1 at acceptance, io_port bits 4:0 equal offset bits 4:0 and io_port bits 15:5 equal offset bits 22:12. Offset bits 11:5 are dropped.
- R5: io_size equals cpu_size (0 = byte, 1 = halfword, 2 = word) and io_write equals cpu_write for the forwarded access.
- R6: Write data to the I/O side follows cpu_big_endian at acceptance. When it is 1, a halfword has bytes 0 and 1 exchanged with the upper 16 bits cleared, and a word has byte k moved to byte 3-k. Byte accesses and accesses with cpu_big_endian 0 pass cpu_wdata unchanged.
- R7: Read data returned from the I/O side follows the same swap rule as R6, using the size and endianness captured at acceptance.
- R8: From acceptance until the response cycle has ended, cpu_ready is 0 and no further access is taken. While io_valid is 1 and io_ready is 0, io_port, io_size, io_write and io_wdata stay stable.
- R9: cpu_done is 1 for one cycle, the cycle after io_valid and io_ready are both 1, and a read carries its data on cpu_rdata in that cycle.
- R10: A read of 0xBFFFFFF0 returns iack_vec zero-extended. Reads of 0xBFFFFFF1 to 0xBFFFFFF3 return 0. Writes to the acknowledge window are ignored. None of these produce an I/O request, and each completes in the cycle after acceptance.
- R11: Halfword and word acknowledge reads are byte-swapped like R7 when cpu_big_endian is 1.
- R12: map_sparse is sampled only at acceptance. Changing it, or cpu_addr, while a request is pending leaves io_port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Bridge idle and able to take a request |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Store data, right-aligned |
| cpu_big_endian | input | 1 | Processor side is big-endian |
| map_sparse | input | 1 | 0 contiguous mapping, 1 sparse mapping |
| iack_vec | input | 8 | Interrupt vector returned by the acknowledge window |
| cpu_done | output | 1 | Response cycle pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_done |
| io_valid | output | 1 | I/O request present |
| io_ready | input | 1 | I/O side accepts and completes the request |
| io_write | output | 1 | I/O request direction |
| io_port | output | 16 | Translated port number |
| io_size | output | 2 | Access size, same coding as cpu_size |
| io_wdata | output | 32 | Store data after lane swap |
| io_rdata | input | 32 | Load data from the I/O side, valid with io_ready |

## Verification
The vector table sweeps all three sizes in both endiannesses. A value whose four bytes all differ shows whether the halfword and word swaps are present and which bytes they move. Sparse addresses are chosen with nonzero offset bits 11:5, which tells the sparse packing apart from plain truncation, and contiguous addresses with offset bits above 15 set show that those bits are dropped. Addresses just past each window edge and the last byte of the I/O window separate correct decoding from off-by-one limits. A stalled request whose mode and address are changed while it waits shows whether the port is captured at acceptance or recomputed.

// File: rtl/io_bridge_pkg.sv
package io_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IO   = 2'd1,
    ST_RESP = 2'd2
  } bridge_state_e;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_IO   = 2'd1,
    RG_IACK = 2'd2
  } region_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_bridge_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              PORT_W     = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
  parameter int              WIN_BYTES  = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] IACK_BASE = 32'hBFFF_FFF0,
  parameter int              IACK_BYTES = 4,
  parameter int              PAGE_SHIFT = 12,
  parameter int              GROUP_BITS = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sparse,
  output region_e           region,
  output logic [PORT_W-1:0] port,
  output logic              iack_vec_sel
);
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam logic [ADDR_W:0] WIN_LO  = {1'b0, WIN_BASE};
  localparam logic [ADDR_W:0] WIN_HI  = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_BYTES);
  localparam logic [ADDR_W:0] IACK_LO = {1'b0, IACK_BASE};
  localparam logic [ADDR_W:0] IACK_HI = {1'b0, IACK_BASE} + (ADDR_W+1)'(IACK_BYTES);

  function automatic logic [PORT_W-1:0] contig_port(input logic [OFF_W-1:0] off);
    return PORT_W'(off);
  endfunction

  function automatic logic [PORT_W-1:0] sparse_port(input logic [OFF_W-1:0] off);
    logic [OFF_W-1:0] page;
    page = off >> PAGE_SHIFT;
    return PORT_W'({page, off[GROUP_BITS-1:0]});
  endfunction

  logic [ADDR_W:0]   addr_x;
  logic [ADDR_W-1:0] diff;
  logic [OFF_W-1:0]  offset;
  logic              hit_io;
  logic              hit_iack;

  always_comb begin
    addr_x   = {1'b0, addr};
    hit_io   = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
    hit_iack = (addr_x >= IACK_LO) && (addr_x < IACK_HI);
    diff     = addr - WIN_BASE;
    offset   = diff[OFF_W-1:0];
    if (hit_io)        region = RG_IO;
    else if (hit_iack) region = RG_IACK;
    else               region = RG_NONE;
    port         = sparse ? sparse_port(offset) : contig_port(offset);
    iack_vec_sel = (addr[3:0] == 4'h0);
  end

endmodule

// File: rtl/io_byte_lane.sv
module io_byte_lane
  import io_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] d,
  input  logic [1:0]        size,
  input  logic              big_endian,
  output logic [DATA_W-1:0] q
);
  localparam int NB = DATA_W / 8;

  always_comb begin
    q = d;
    if (big_endian) begin
      if (size == SZ_HALF) begin
        q        = '0;
        q[7:0]   = d[15:8];
        q[15:8]  = d[7:0];
      end else if (size != SZ_BYTE) begin
        for (int i = 0; i < NB; i++) begin
          q[8*i +: 8] = d[8*(NB-1-i) +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/io_bridge_ctrl.sv
module io_bridge_ctrl
  import io_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_be,
  input  region_e           region,
  input  logic [PORT_W-1:0] xl_port,
  input  logic [DATA_W-1:0] wdata_sw,
  input  logic [DATA_W-1:0] rd_sw,
  input  logic              io_ready,
  output bridge_state_e     state,
  output logic              lat_write,
  output logic [1:0]        lat_size,
  output logic              lat_be,
  output logic [PORT_W-1:0] lat_port,
  output logic [DATA_W-1:0] lat_wdata,
  output logic [DATA_W-1:0] rsp_data,
  output logic              acc_fire,
  output logic              io_fire
);
  assign acc_fire = cpu_valid && (state == ST_IDLE);
  assign io_fire  = (state == ST_IO) && io_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_write <= 1'b0;
      lat_size  <= SZ_BYTE;
      lat_be    <= 1'b0;
      lat_port  <= '0;
      lat_wdata <= '0;
      rsp_data  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (acc_fire) begin
            lat_write <= cpu_write;
            lat_size  <= cpu_size;
            lat_be    <= cpu_be;
            lat_port  <= xl_port;
            lat_wdata <= wdata_sw;
            if (region == RG_IO) begin
              state <= ST_IO;
            end else begin
              rsp_data <= rd_sw;
              state    <= ST_RESP;
            end
          end
        end
        ST_IO: begin
          if (io_ready) begin
            rsp_data <= lat_write ? '0 : rd_sw;
            state    <= ST_RESP;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/io_window_bridge.sv
module io_window_bridge
  import io_bridge_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                PORT_W     = 16,
  parameter int                VEC_W      = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
  parameter int                WIN_BYTES  = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] IACK_BASE  = 32'hBFFF_FFF0,
  parameter int                IACK_BYTES = 4,
  parameter int                PAGE_SHIFT = 12,
  parameter int                GROUP_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_big_endian,
  input  logic              map_sparse,
  input  logic [VEC_W-1:0]  iack_vec,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              io_valid,
  input  logic              io_ready,
  output logic              io_write,
  output logic [PORT_W-1:0] io_port,
  output logic [1:0]        io_size,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata
);
  region_e           region;
  logic [PORT_W-1:0] xl_port;
  logic              iack_vec_sel;
  logic [DATA_W-1:0] wdata_sw;
  logic [DATA_W-1:0] rd_raw;
  logic [DATA_W-1:0] rd_sw;
  logic [1:0]        rd_size;
  logic              rd_be;
  logic [DATA_W-1:0] local_rd;
  bridge_state_e     state;
  logic              lat_write;
  logic [1:0]        lat_size;
  logic              lat_be;
  logic [PORT_W-1:0] lat_port;
  logic [DATA_W-1:0] lat_wdata;
  logic [DATA_W-1:0] rsp_data;

  // named events for the checker
  logic acc_fire;
  logic io_fire;
  logic acc_io;
  logic acc_local;

  io_addr_decode #(
    .ADDR_W    (ADDR_W),
    .PORT_W    (PORT_W),
    .WIN_BASE  (WIN_BASE),
    .WIN_BYTES (WIN_BYTES),
    .IACK_BASE (IACK_BASE),
    .IACK_BYTES(IACK_BYTES),
    .PAGE_SHIFT(PAGE_SHIFT),
    .GROUP_BITS(GROUP_BITS)
  ) u_decode (
    .addr        (cpu_addr),
    .sparse      (map_sparse),
    .region      (region),
    .port        (xl_port),
    .iack_vec_sel(iack_vec_sel)
  );

  io_byte_lane #(.DATA_W(DATA_W)) u_wr_lane (
    .d         (cpu_wdata),
    .size      (cpu_size),
    .big_endian(cpu_big_endian),
    .q         (wdata_sw)
  );

  always_comb begin
    local_rd = '0;
    if (region == RG_IACK && !cpu_write && iack_vec_sel) begin
      local_rd = DATA_W'(iack_vec);
    end
    if (state == ST_IO) begin
      rd_raw  = io_rdata;
      rd_size = lat_size;
      rd_be   = lat_be;
    end else begin
      rd_raw  = local_rd;
      rd_size = cpu_size;
      rd_be   = cpu_big_endian;
    end
  end

  io_byte_lane #(.DATA_W(DATA_W)) u_rd_lane (
    .d         (rd_raw),
    .size      (rd_size),
    .big_endian(rd_be),
    .q         (rd_sw)
  );

  io_bridge_ctrl #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_valid(cpu_valid),
    .cpu_write(cpu_write),
    .cpu_size (cpu_size),
    .cpu_be   (cpu_big_endian),
    .region   (region),
    .xl_port  (xl_port),
    .wdata_sw (wdata_sw),
    .rd_sw    (rd_sw),
    .io_ready (io_ready),
    .state    (state),
    .lat_write(lat_write),
    .lat_size (lat_size),
    .lat_be   (lat_be),
    .lat_port (lat_port),
    .lat_wdata(lat_wdata),
    .rsp_data (rsp_data),
    .acc_fire (acc_fire),
    .io_fire  (io_fire)
  );

  assign acc_io    = acc_fire && (region == RG_IO);
  assign acc_local = acc_fire && (region != RG_IO);

  assign cpu_ready = (state == ST_IDLE);
  assign cpu_done  = (state == ST_RESP);
  assign cpu_rdata = rsp_data;
  assign io_valid  = (state == ST_IO);
  assign io_write  = lat_write;
  assign io_port   = lat_port;
  assign io_size   = lat_size;
  assign io_wdata  = lat_wdata;

endmodule

// File: rtl/io_window_bridge_chk.sv
module io_window_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ready,
  input logic        cpu_write,
  input logic [31:0] cpu_addr,
  input logic [1:0]  cpu_size,
  input logic        map_sparse,
  input logic        cpu_done,
  input logic        io_valid,
  input logic        io_ready,
  input logic        io_write,
  input logic [15:0] io_port,
  input logic [1:0]  io_size,
  input logic [31:0] io_wdata,
  input logic        io_fire,
  input logic        acc_io,
  input logic        acc_local
);

  assert_window_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_io |-> (cpu_addr[31:23] == 9'h100));

  assert_local_no_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_local |=> (cpu_done && !io_valid));

  assert_contig_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_io && !map_sparse) |=> (io_port == $past(cpu_addr[15:0])));

  assert_sparse_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_io && map_sparse) |=>
      (io_port == {$past(cpu_addr[22:12]), $past(cpu_addr[4:0])}));

  assert_size_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_io |=> (io_valid && io_size == $past(cpu_size) && io_write == $past(cpu_write)));

  assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_ready) |=>
      (io_valid && $stable(io_port) && $stable(io_size) &&
       $stable(io_write) && $stable(io_wdata)));

  assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_ready, io_valid, cpu_done}));

  assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_fire |=> (cpu_done && !io_valid));

endmodule

bind io_window_bridge io_window_bridge_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .cpu_write (cpu_write),
  .cpu_addr  (cpu_addr),
  .cpu_size  (cpu_size),
  .map_sparse(map_sparse),
  .cpu_done  (cpu_done),
  .io_valid  (io_valid),
  .io_ready  (io_ready),
  .io_write  (io_write),
  .io_port   (io_port),
  .io_size   (io_size),
  .io_wdata  (io_wdata),
  .io_fire   (io_fire),
  .acc_io    (acc_io),
  .acc_local (acc_local)
);

// File: tb/io_window_bridge_tb.sv
module io_window_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] VEC = 8'h2B;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        be;
    logic        sp;
    logic [31:0] iord;
    logic        fwd;
    logic [15:0] eport;
    logic [31:0] ewd;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 32'h8000_1234, 32'h0,         1'b0, 1'b0, 32'h0000_00A5, 1'b1, 16'h1234, 32'h0,         32'h0000_00A5},
    '{1'b1, 2'd1, 32'h8000_03F8, 32'h0000_BEEF, 1'b1, 1'b0, 32'h0,         1'b1, 16'h03F8, 32'h0000_EFBE, 32'h0},
    '{1'b1, 2'd2, 32'h8001_0070, 32'h1122_3344, 1'b1, 1'b0, 32'h0,         1'b1, 16'h0070, 32'h4433_2211, 32'h0},
    '{1'b0, 2'd2, 32'h8000_0CF8, 32'h0,         1'b1, 1'b0, 32'hAABB_CCDD, 1'b1, 16'h0CF8, 32'h0,         32'hDDCC_BBAA},
    '{1'b0, 2'd1, 32'h8000_0060, 32'h0,         1'b0, 1'b0, 32'h0000_1357, 1'b1, 16'h0060, 32'h0,         32'h0000_1357},
    '{1'b1, 2'd0, 32'h8000_3015, 32'h0000_005A, 1'b1, 1'b1, 32'h0,         1'b1, 16'h0075, 32'h0000_005A, 32'h0},
    '{1'b0, 2'd1, 32'h807F_F3E2, 32'h0,         1'b1, 1'b1, 32'h0000_CAFE, 1'b1, 16'hFFE2, 32'h0,         32'h0000_FECA},
    '{1'b0, 2'd2, 32'h8012_345F, 32'h0,         1'b0, 1'b1, 32'h0102_0304, 1'b1, 16'h247F, 32'h0,         32'h0102_0304},
    '{1'b1, 2'd0, 32'h8055_ABCD, 32'h0000_0077, 1'b0, 1'b0, 32'h0,         1'b1, 16'hABCD, 32'h0000_0077, 32'h0},
    '{1'b0, 2'd2, 32'h7FFF_FFFC, 32'h0,         1'b0, 1'b0, 32'h0,         1'b0, 16'h0,    32'h0,         32'h0},
    '{1'b1, 2'd2, 32'h8080_0000, 32'h0102_0304, 1'b0, 1'b0, 32'h0,         1'b0, 16'h0,    32'h0,         32'h0},
    '{1'b0, 2'd0, 32'h807F_FFFF, 32'h0,         1'b1, 1'b0, 32'h0000_003C, 1'b1, 16'hFFFF, 32'h0,         32'h0000_003C},
    '{1'b0, 2'd0, 32'hBFFF_FFF0, 32'h0,         1'b0, 1'b0, 32'h0,         1'b0, 16'h0,    32'h0,         32'h0000_002B},
    '{1'b0, 2'd2, 32'hBFFF_FFF0, 32'h0,         1'b1, 1'b0, 32'h0,         1'b0, 16'h0,    32'h0,         32'h2B00_0000},
    '{1'b0, 2'd1, 32'hBFFF_FFF0, 32'h0,         1'b1, 1'b0, 32'h0,         1'b0, 16'h0,    32'h0,         32'h0000_2B00},
    '{1'b0, 2'd0, 32'hBFFF_FFF2, 32'h0,         1'b0, 1'b0, 32'h0,         1'b0, 16'h0,    32'h0,         32'h0},
    '{1'b1, 2'd2, 32'hBFFF_FFF0, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0,         1'b0, 16'h0,    32'h0,         32'h0},
    '{1'b0, 2'd2, 32'hBFFF_FFF4, 32'h0,         1'b0, 1'b0, 32'h0,         1'b0, 16'h0,    32'h0,         32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid;
  logic        cpu_ready;
  logic        cpu_write;
  logic [31:0] cpu_addr;
  logic [1:0]  cpu_size;
  logic [31:0] cpu_wdata;
  logic        cpu_big_endian;
  logic        map_sparse;
  logic [7:0]  iack_vec;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        io_valid;
  logic        io_ready;
  logic        io_write;
  logic [15:0] io_port;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_window_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .cpu_big_endian(cpu_big_endian), .map_sparse(map_sparse), .iack_vec(iack_vec),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .io_valid(io_valid), .io_ready(io_ready), .io_write(io_write),
    .io_port(io_port), .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    logic  in_iack;
    string rtag;
    in_iack = (v.addr >= 32'hBFFF_FFF0) && (v.addr < 32'hBFFF_FFF4);
    if (in_iack)    rtag = (v.sz != 2'd0 && v.be) ? "R11" : "R10";
    else if (v.fwd) rtag = "R7";
    else            rtag = "R2";
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = v.wr; cpu_size = v.sz; cpu_addr = v.addr;
    cpu_wdata = v.wd; cpu_big_endian = v.be; map_sparse = v.sp;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    check("R2", $sformatf("vec%0d forwarded", idx), {31'b0, io_valid}, {31'b0, v.fwd});
    if (v.fwd) begin
      check("R8", $sformatf("vec%0d ready low", idx), {31'b0, cpu_ready}, 32'h0);
      check(v.sp ? "R4" : "R3", $sformatf("vec%0d port", idx), {16'b0, io_port}, {16'b0, v.eport});
      check("R5", $sformatf("vec%0d size/dir", idx), {29'b0, io_write, io_size}, {29'b0, v.wr, v.sz});
      if (v.wr) check("R6", $sformatf("vec%0d wdata", idx), io_wdata, v.ewd);
      io_ready = 1'b1; io_rdata = v.iord;
      @(posedge clk);
      @(negedge clk);
      io_ready = 1'b0; io_rdata = 32'hDEAD_BEEF;
      check("R9", $sformatf("vec%0d done", idx), {31'b0, cpu_done}, 32'h1);
      if (!v.wr) check(rtag, $sformatf("vec%0d rdata", idx), cpu_rdata, v.erd);
    end else begin
      check(in_iack ? "R10" : "R2", $sformatf("vec%0d done", idx), {31'b0, cpu_done}, 32'h1);
      if (!v.wr) check(rtag, $sformatf("vec%0d rdata", idx), cpu_rdata, v.erd);
    end
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0; cpu_addr = '0;
    cpu_size = 2'd0; cpu_wdata = '0; cpu_big_endian = 1'b0; map_sparse = 1'b0;
    iack_vec = VEC; io_ready = 1'b0; io_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "ready in reset", {31'b0, cpu_ready}, 32'h1);
    check("R1", "io_valid in reset", {31'b0, io_valid}, 32'h0);
    check("R1", "done in reset", {31'b0, cpu_done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", {31'b0, cpu_ready}, 32'h1);

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    // R8 and R12: stalled request, mode and address change while pending
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_size = 2'd0;
    cpu_addr = 32'h8000_3015; map_sparse = 1'b0; cpu_big_endian = 1'b0;
    @(posedge clk);
    @(negedge clk);
    map_sparse = 1'b1; cpu_addr = 32'h8000_1000;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R12", "port after mode change", {16'b0, io_port}, 32'h0000_3015);
      check("R8", "ready low while pending", {31'b0, cpu_ready}, 32'h0);
      check("R8", "request held", {31'b0, io_valid}, 32'h1);
    end
    io_ready = 1'b1; io_rdata = 32'h0000_0099;
    @(posedge clk);
    @(negedge clk);
    io_ready = 1'b0;
    check("R9", "stalled read data", cpu_rdata, 32'h0000_0099);
    check("R8", "ready low in response", {31'b0, cpu_ready}, 32'h0);
    cpu_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8", "idle after response", {31'b0, cpu_ready}, 32'h1);
    check("R2", "no stray request", {31'b0, io_valid}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule